// File: doc/BRIEF.md
# Signed-Reference Correlator Lane Array

This block forms the multiply stage of a cross-correlation in which the reference sequence carries one bit per tap. Two independent delay lines feed it: a line of sample words and a line of reference bits, each as deep as the lane count. Every lane takes its stored sample, reads it as an offset-binary code, turns it into a signed value and then keeps or negates it according to its reference bit. A set bit stands for +1 and a clear bit for -1, so no multiplier is needed. All lane products are presented in parallel, and a registered total of the products is also provided for downstream peak search.

Samples and reference bits enter through two separate valid/ready streams, so either line can advance without the other. The block never applies back-pressure once running. Each ready output is low while reset is held and during the first clock edge of reset, and is high from the first edge after reset is released. A word is taken on every rising edge where valid and ready are both high. The upstream source must keep its data steady while valid is high and ready is low. Outside a transfer the lines hold their contents.

Top module: `corr_lane_array`

## Requirements
- R1: While reset is held, every lane's sample entry is cleared to code 0x00 and every reference bit to 0. Every lane product therefore reads +128.
- R2: On a sample transfer, the new word is stored in lane 0 and each lane i>0 takes the word lane i-1 held. The word in the last lane is dropped. Without a transfer, the stored samples do not change.
- R3: On a reference transfer, the new bit is stored in lane 0 and the bits move up by one lane in the same way. This is independent of sample transfers. Without a transfer, the stored bits do not change.
- R4: A lane whose reference bit is 1 outputs its sample code minus 128, as a 9-bit two's complement value. This is the code with its top bit inverted, then sign-extended.
- R5: A lane whose reference bit is 0 outputs 128 minus its sample code, which is the negation of the R4 value.
- R6: Lane products stay within -128 to +128 with no wrap. Code 0x00 with reference 0 gives +128, and code 0x00 with reference 1 gives -128.
- R7: The total output equals the signed sum of all lane products as they stood before the previous rising edge. It is 12 bits wide for 8 lanes, which covers ±1024.
- R8: Both ready outputs are 0 after a reset edge and 1 on every edge after one where reset was low.
- R9: A reset edge clears the total to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_data | input | SAMPLE_W (8) | Offset-binary sample word |
| ref_valid | input | 1 | Reference stream valid |
| ref_ready | output | 1 | Reference stream ready |
| ref_bit | input | 1 | Reference bit, 1 = +1, 0 = -1 |
| prod_o | output | LANES*(SAMPLE_W+1) (72) | Lane products; lane i at bits [i*9 +: 9] |
| sum_o | output | SUM_W (12) | Registered signed total of the products |

## Verification
The bench builds the block with its defaults: 8 lanes of 8-bit samples. Eight transfers fill a line completely, so the directed cases can set every lane to the code 0x00 extreme, with either reference polarity, and drive the total to both full-scale limits, +1024 and -1024. At this width, random codes cover the whole 256-value input range. Random valid patterns move the two lines out of step with each other.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // Offset-binary to two's complement: flip the top bit.
  function automatic logic [7:0] ob_flip8(input logic [7:0] code);
    return {~code[7], code[6:0]};
  endfunction

  // Total width needed for n lanes of w-bit samples, plus sign.
  function automatic int sum_width(input int n, input int w);
    return $clog2(n * (2 ** (w - 1)) + 1) + 1;
  endfunction

endpackage

// File: rtl/corr_shift_line.sv
module corr_shift_line #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [WIDTH-1:0]             din,
  output logic [DEPTH-1:0][WIDTH-1:0]  q
);

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)     q[0] <= '0;
        else if (en) q[0] <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {q[DEPTH-2:0], din};
      end
    end
  endgenerate

endmodule

// File: rtl/corr_lane.sv
module corr_lane #(
  parameter int SAMPLE_W = 8,
  localparam int PROD_W  = SAMPLE_W + 1
) (
  input  logic [SAMPLE_W-1:0] code,
  input  logic                pos,
  output logic [PROD_W-1:0]   prod
);

  logic [SAMPLE_W-1:0] tc;
  logic [PROD_W-1:0]   ext;

  always_comb begin
    tc   = {~code[SAMPLE_W-1], code[SAMPLE_W-2:0]};
    ext  = {tc[SAMPLE_W-1], tc};
    prod = pos ? ext : (PROD_W'(0) - ext);
  end

endmodule

// File: rtl/corr_sum.sv
module corr_sum #(
  parameter int LANES  = 8,
  parameter int PROD_W = 9,
  parameter int SUM_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0][PROD_W-1:0]  prod,
  output logic [SUM_W-1:0]              total
);

  logic [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      acc = acc + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) total <= '0;
    else     total <= acc;
  end

endmodule

// File: rtl/corr_lane_array.sv
module corr_lane_array #(
  parameter int LANES    = 8,
  parameter int SAMPLE_W = 8,
  localparam int PROD_W  = SAMPLE_W + 1,
  localparam int SUM_W   = $clog2(LANES * (2 ** (SAMPLE_W - 1)) + 1) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      smp_valid,
  output logic                      smp_ready,
  input  logic [SAMPLE_W-1:0]       smp_data,
  input  logic                      ref_valid,
  output logic                      ref_ready,
  input  logic                      ref_bit,
  output logic [LANES*PROD_W-1:0]   prod_o,
  output logic [SUM_W-1:0]          sum_o
);

  logic                              rdy_q;
  logic                              smp_take;
  logic                              ref_take;
  logic [LANES-1:0][SAMPLE_W-1:0]    smp_q;
  logic [LANES-1:0][0:0]             ref_q;
  logic [LANES-1:0][PROD_W-1:0]      prod_w;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign smp_ready = rdy_q;
  assign ref_ready = rdy_q;
  assign smp_take  = smp_valid & rdy_q;
  assign ref_take  = ref_valid & rdy_q;

  corr_shift_line #(.DEPTH(LANES), .WIDTH(SAMPLE_W)) u_smp_line (
    .clk (clk),
    .rst (rst),
    .en  (smp_take),
    .din (smp_data),
    .q   (smp_q)
  );

  corr_shift_line #(.DEPTH(LANES), .WIDTH(1)) u_ref_line (
    .clk (clk),
    .rst (rst),
    .en  (ref_take),
    .din (ref_bit),
    .q   (ref_q)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      corr_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
        .code (smp_q[i]),
        .pos  (ref_q[i][0]),
        .prod (prod_w[i])
      );
      assign prod_o[i*PROD_W +: PROD_W] = prod_w[i];
    end
  endgenerate

  corr_sum #(.LANES(LANES), .PROD_W(PROD_W), .SUM_W(SUM_W)) u_sum (
    .clk   (clk),
    .rst   (rst),
    .prod  (prod_w),
    .total (sum_o)
  );

endmodule

// File: rtl/corr_lane_array_chk.sv
module corr_lane_array_chk #(
  parameter int LANES    = 8,
  parameter int SAMPLE_W = 8,
  parameter int PROD_W   = 9,
  parameter int SUM_W    = 12
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          smp_valid,
  input logic                          smp_ready,
  input logic [SAMPLE_W-1:0]           smp_data,
  input logic                          ref_valid,
  input logic                          ref_ready,
  input logic                          ref_bit,
  input logic [LANES-1:0][SAMPLE_W-1:0] smp_q,
  input logic [LANES-1:0][0:0]         ref_q,
  input logic [LANES*PROD_W-1:0]       prod_o,
  input logic [SUM_W-1:0]              sum_o
);

  logic [SUM_W-1:0] chk_sum;

  always_comb begin
    chk_sum = '0;
    for (int i = 0; i < LANES; i++) begin
      chk_sum = chk_sum + SUM_W'($signed(prod_o[i*PROD_W +: PROD_W]));
    end
  end

  a_r2_enter: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready) |=> smp_q[0] == $past(smp_data));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && smp_ready) |=> $stable(smp_q));

  a_r3_enter: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && ref_ready) |=> ref_q[0][0] == $past(ref_bit));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !(ref_valid && ref_ready) |=> $stable(ref_q));

  a_r7_total: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sum_o == $past(chk_sum));

  a_r8_ready: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (smp_ready && ref_ready));

  a_r9_clear: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && !smp_ready && !ref_ready));

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_rng
      a_r6_range: assert property (@(posedge clk) disable iff (rst)
        ($signed(prod_o[i*PROD_W +: PROD_W]) <= $signed(PROD_W'(2 ** (SAMPLE_W - 1))) &&
         $signed(prod_o[i*PROD_W +: PROD_W]) >= $signed(-PROD_W'(2 ** (SAMPLE_W - 1)))));
    end
  endgenerate

endmodule

bind corr_lane_array corr_lane_array_chk #(
  .LANES(LANES), .SAMPLE_W(SAMPLE_W), .PROD_W(PROD_W), .SUM_W(SUM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .smp_data  (smp_data),
  .ref_valid (ref_valid),
  .ref_ready (ref_ready),
  .ref_bit   (ref_bit),
  .smp_q     (smp_q),
  .ref_q     (ref_q),
  .prod_o    (prod_o),
  .sum_o     (sum_o)
);

// File: tb/tb_corr_lane_array.sv
`timescale 1ns/1ps
module tb_corr_lane_array;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int PW = 9;
  localparam int SW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [W-1:0] smp_data = '0;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic ref_bit = 1'b0;
  logic [N*PW-1:0] prod_o;
  logic [SW-1:0] sum_o;

  int total = 0;
  int bad = 0;
  int m_smp [N];
  bit m_ref [N];
  int exp_sum = 0;

  always #4 clk = ~clk;

  corr_lane_array #(.LANES(N), .SAMPLE_W(W)) dut (
    .clk(clk), .rst(rst),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_bit(ref_bit),
    .prod_o(prod_o), .sum_o(sum_o)
  );

  function automatic int exp_prod(int code, bit r);
    int c = code - 128;
    return r ? c : -c;
  endfunction

  function automatic int model_sum();
    int s = 0;
    for (int i = 0; i < N; i++) s += exp_prod(m_smp[i], m_ref[i]);
    return s;
  endfunction

  function automatic int lane_val(int i);
    return int'($signed(prod_o[i*PW +: PW]));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    for (int i = 0; i < N; i++) begin
      int e = exp_prod(m_smp[i], m_ref[i]);
      string t = (tag != "") ? tag : ((e == 128 || e == -128) ? "R6" : (m_ref[i] ? "R4" : "R5"));
      check(lane_val(i) == e, t, lane_val(i), e);
    end
    check(int'($signed(sum_o)) == exp_sum, "R7", int'($signed(sum_o)), exp_sum);
    check(smp_ready && ref_ready, "R8", int'({smp_ready, ref_ready}), 3);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(bit sv, int sd, bit rv, bit rd, string tag);
    smp_valid = sv; smp_data = W'(sd);
    ref_valid = rv; ref_bit = rd;
    @(posedge clk);
    exp_sum = model_sum();
    if (sv) begin
      for (int i = N-1; i > 0; i--) m_smp[i] = m_smp[i-1];
      m_smp[0] = sd;
    end
    if (rv) begin
      for (int i = N-1; i > 0; i--) m_ref[i] = m_ref[i-1];
      m_ref[0] = rd;
    end
    @(negedge clk);
    smp_valid = 1'b0; ref_valid = 1'b0;
    check_outputs(tag);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_smp[i] = 0; m_ref[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    check(smp_ready == 1'b0 && ref_ready == 1'b0, "R8", int'({smp_ready, ref_ready}), 0);
    check(sum_o == '0, "R9", int'($signed(sum_o)), 0);
    for (int i = 0; i < N; i++) check(lane_val(i) == 128, "R1", lane_val(i), 128);
    rst = 1'b0;

    // all lanes 0x00 with reference 0: +128 each, total +1024
    for (int k = 0; k < N; k++) step(1, 0, 1, 0, "");
    step(0, 0, 0, 0, "R6");
    check(int'($signed(sum_o)) == 1024, "R7", int'($signed(sum_o)), 1024);
    // flip reference to 1: -128 each, total -1024
    for (int k = 0; k < N; k++) step(0, 0, 1, 1, "R3");
    step(0, 0, 0, 0, "R6");
    check(int'($signed(sum_o)) == -1024, "R7", int'($signed(sum_o)), -1024);
    // top codes and midscale
    for (int k = 0; k < N; k++) step(1, (k % 2) ? 8'hFF : 8'h80, 0, 0, "R2");
    for (int k = 0; k < 4; k++) step(0, 0, 1, k % 2, "");
    // idle: held contents
    for (int k = 0; k < 4; k++) step(0, 8'h5A, 0, 1, "R2");

    // random traffic, lines advancing out of step
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 3) != 0, $urandom % 256, ($urandom % 2) != 0, ($urandom % 2) != 0, "");
    end

    // reset in mid-run clears the total again
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(sum_o == '0, "R9", int'($signed(sum_o)), 0);
    check(smp_ready == 1'b0, "R8", int'(smp_ready), 0);
    for (int i = 0; i < N; i++) check(lane_val(i) == 128, "R1", lane_val(i), 128);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule